// File: doc/BRIEF.md
# Integrating converter conversion sequencer

This block generates the digital timing skeleton of a dual-slope integrating converter. The incoming clock is divided by four to form an internal step rate. Each conversion is then paced over a fixed frame of 1280 internal steps. The frame has three parts: a run-up phase of 836 steps, a run-down phase of 319 steps, and a rest interval of 125 steps.

A busy flag is high through run-up and run-down. When busy falls, a one-clock strobe marks the point where a new result is valid, and the block captures the result word on that same edge. An active flag stays high for the whole frame, rest included.

The block has two ways of starting a conversion:
- **Demand mode.** A conversion starts on a falling edge of the active-low write strobe, taken while both select inputs are high. Write edges that arrive early in a conversion are dropped. A write edge that arrives late in a conversion is held and starts the next frame without a gap.
- **Continuous mode.** Frames follow one another with no write at all.

The analog front end is not part of this block. A stand-in result word comes in on a plain input.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, and with no qualifying write in demand mode, `busy_o`, `active_o` and `latch_o` are 0 and `data_o` is all zeros.
- R2: In demand mode (`cont_mode_i` = 0), a falling edge on `wr_ni` while `chip_sel_i` = 1 and `chip_en_i` = 1 (both active high) raises `busy_o` within 8 clock cycles.
- R3: Once `busy_o` rises, it stays high for exactly 4620 clocks (1155 internal steps of 4 clocks: 836 run-up plus 319 run-down), then falls.
- R4: `latch_o` is high for exactly one clock, in the first cycle in which `busy_o` is low again. In that same cycle `data_o` takes the value that `result_i` had at the falling edge of busy. `data_o` changes at no other time.
- R5: After `busy_o` falls, `active_o` stays high for 500 more clocks (125 internal steps) and then drops if no new conversion follows.
- R6: A falling edge on `wr_ni` while either `chip_sel_i` or `chip_en_i` is 0 starts no conversion.
- R7: A qualified write edge within the first 1100 internal steps (4400 clocks) of a conversion is discarded.
- R8: A qualified write edge after the 1100-step point is held. The next conversion then begins exactly 500 clocks after `busy_o` falls.
- R9: Holding `wr_ni` low starts no further conversions after the one its falling edge triggered.
- R10: In continuous mode (`cont_mode_i` = 1), conversions repeat with `busy_o` rising exactly 500 clocks after each fall, and write edges have no effect. After the mode returns to 0, the current frame finishes and no new one begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cont_mode_i | input | 1 | 1 = continuous, 0 = demand |
| chip_sel_i | input | 1 | Write qualifier, active high |
| chip_en_i | input | 1 | Second write qualifier, active high |
| wr_ni | input | 1 | Write strobe, active low; its falling edge requests a conversion |
| result_i | input | RES_W | Stand-in conversion result |
| busy_o | output | 1 | High during run-up and run-down |
| active_o | output | 1 | High for the whole conversion frame |
| latch_o | output | 1 | One-clock strobe when a new result is captured |
| data_o | output | RES_W | Captured result |

## Verification
If the internal step counter drifts or skips a phase boundary, the busy width moves away from 4620 clocks. That shows up at the very first falling edge of busy, and the frame-to-frame gap of 500 clocks breaks on the next restart. If the pending-write flag is wrong, it shows as an extra conversion, or a missing one, exactly 500 clocks after busy falls. If the lockout compare is wrong, an early write restarts the block at that same point instead of leaving it idle. A wrong capture enable shows on `data_o` at the first falling edge of busy. That value is compared against the result word queued for that conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUNUP = 2'd1,
    PH_RUNDN = 2'd2,
    PH_REST  = 2'd3
  } phase_e;
endpackage

// File: rtl/conv_tick_div.sv
module conv_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt_q;

  assign tick_o = (cnt_q == DW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/conv_wr_detect.sv
module conv_wr_detect #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  input  logic chip_sel_i,
  input  logic chip_en_i,
  output logic fall_o
);
  // sync_q[SYNC-1] is the synchronised level, sync_q[SYNC] its previous value
  logic [SYNC:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-1:0], wr_ni};
  end

  assign fall_o = sync_q[SYNC] & ~sync_q[SYNC-1] & chip_sel_i & chip_en_i;
endmodule

// File: rtl/conv_phase_ctl.sv
module conv_phase_ctl
  import conv_seq_pkg::*;
#(
  parameter int unsigned RUNUP   = 836,
  parameter int unsigned RUNDN   = 319,
  parameter int unsigned CYCLE   = 1280,
  parameter int unsigned LOCKOUT = 1100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cont_i,
  input  logic wr_fall_i,
  output logic busy_o,
  output logic active_o,
  output logic latch_o,
  output logic capture_o
);
  localparam int unsigned CW = $clog2(CYCLE);

  phase_e        state_q, state_d;
  logic [CW-1:0] step_q, step_d;
  logic          pend_q, pend_d;
  logic          latch_q;
  logic          start, go, accept;
  logic          runup_end, busy_end, frame_end, locked;

  assign runup_end = (step_q == CW'(RUNUP - 1));
  assign busy_end  = (step_q == CW'(RUNUP + RUNDN - 1));
  assign frame_end = (step_q == CW'(CYCLE - 1));
  assign locked    = (step_q < CW'(LOCKOUT));
  assign go        = pend_q | cont_i;
  // writes count only in demand mode, when idle or past the lockout window
  assign accept    = wr_fall_i & ~cont_i & ((state_q == PH_IDLE) | ~locked);

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    start     = 1'b0;
    capture_o = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        PH_IDLE: if (go) start = 1'b1;
        PH_RUNUP: begin
          step_d = step_q + CW'(1);
          if (runup_end) state_d = PH_RUNDN;
        end
        PH_RUNDN: begin
          step_d = step_q + CW'(1);
          if (busy_end) begin
            state_d   = PH_REST;
            capture_o = 1'b1;
          end
        end
        PH_REST: begin
          if (frame_end) begin
            step_d  = '0;
            state_d = PH_IDLE;
            if (go) start = 1'b1;
          end else begin
            step_d = step_q + CW'(1);
          end
        end
        default: state_d = PH_IDLE;
      endcase
    end
    if (start) begin
      state_d = PH_RUNUP;
      step_d  = '0;
    end
  end

  always_comb begin
    if (start)       pend_d = 1'b0;
    else if (accept) pend_d = 1'b1;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      step_q  <= '0;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      pend_q  <= pend_d;
      latch_q <= capture_o;
    end
  end

  assign busy_o   = (state_q == PH_RUNUP) | (state_q == PH_RUNDN);
  assign active_o = (state_q != PH_IDLE);
  assign latch_o  = latch_q;
endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold #(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (capture_i) data_o <= result_i;
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int unsigned DIV          = 4,
  parameter int unsigned RUNUP_TICKS  = 836,
  parameter int unsigned RUNDN_TICKS  = 319,
  parameter int unsigned REST_TICKS   = 125,
  parameter int unsigned LOCK_TICKS   = 1100,
  parameter int unsigned SYNC         = 2,
  parameter int unsigned RES_W        = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cont_mode_i,
  input  logic             chip_sel_i,
  input  logic             chip_en_i,
  input  logic             wr_ni,
  input  logic [RES_W-1:0] result_i,
  output logic             busy_o,
  output logic             active_o,
  output logic             latch_o,
  output logic [RES_W-1:0] data_o
);
  localparam int unsigned CYCLE_TICKS = RUNUP_TICKS + RUNDN_TICKS + REST_TICKS;

  logic tick, wr_fall, capture;

  conv_tick_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  conv_wr_detect #(.SYNC(SYNC)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ni     (wr_ni),
    .chip_sel_i(chip_sel_i),
    .chip_en_i (chip_en_i),
    .fall_o    (wr_fall)
  );

  conv_phase_ctl #(
    .RUNUP  (RUNUP_TICKS),
    .RUNDN  (RUNDN_TICKS),
    .CYCLE  (CYCLE_TICKS),
    .LOCKOUT(LOCK_TICKS)
  ) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cont_i   (cont_mode_i),
    .wr_fall_i(wr_fall),
    .busy_o   (busy_o),
    .active_o (active_o),
    .latch_o  (latch_o),
    .capture_o(capture)
  );

  conv_result_hold #(.RES_W(RES_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .result_i (result_i),
    .data_o   (data_o)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int unsigned BUSY_CLKS = 4620,
  parameter int unsigned RES_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             active_o,
  input logic             latch_o,
  input logic [RES_W-1:0] data_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  // R3
  busy_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == BUSY_CLKS));

  // R4
  latch_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> latch_o);

  // R4
  latch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);

  // R4
  data_only_on_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> latch_o);

  // R5
  busy_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> active_o);

  // R5
  rest_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (active_o && !busy_o));
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .BUSY_CLKS(DIV * (RUNUP_TICKS + RUNDN_TICKS)),
  .RES_W    (RES_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .active_o(active_o),
  .latch_o (latch_o),
  .data_o  (data_o)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  localparam int RES_W    = 16;
  localparam int BUSY_CLK = 4620;
  localparam int REST_CLK = 500;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cont_mode = 1'b0;
  logic             chip_sel = 1'b0;
  logic             chip_en = 1'b0;
  logic             wr_n = 1'b1;
  logic [RES_W-1:0] result = '0;
  logic             busy, active, latch;
  logic [RES_W-1:0] data;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint rise_cyc = 0, fall_cyc = 0, wr_cyc = 0;
  int rise_cnt = 0, fall_cnt = 0;
  bit prev_busy = 1'b0;
  bit done = 1'b0;
  logic [RES_W-1:0] exp_q[$];

  always #5 clk = ~clk;

  conv_sequencer u_conv_sequencer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cont_mode_i(cont_mode),
    .chip_sel_i (chip_sel),
    .chip_en_i  (chip_en),
    .wr_ni      (wr_n),
    .result_i   (result),
    .busy_o     (busy),
    .active_o   (active),
    .latch_o    (latch),
    .data_o     (data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push_result(input logic [RES_W-1:0] v);
    result = v;
    exp_q.push_back(v);
  endtask

  task automatic wr_fall(input bit sel, input bit en);
    chip_sel = sel;
    chip_en  = en;
    wr_n     = 1'b0;
    wr_cyc   = cyc;
  endtask

  // monitor: busy edges, width, latch and scoreboard pop
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (busy && !prev_busy) begin
        rise_cnt++;
        rise_cyc = cyc;
      end
      if (!busy && prev_busy) begin
        fall_cnt++;
        fall_cyc = cyc;
        chk(cyc - rise_cyc == BUSY_CLK, "R3 busy width", cyc - rise_cyc, BUSY_CLK);
        chk(latch == 1'b1, "R4 latch at busy fall", latch, 1);
      end
      if (latch) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected latch", data, 0);
        else begin
          logic [RES_W-1:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R4 captured data", data, e);
        end
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    step(100);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(active == 0, "R1 active", active, 0);
    chk(latch == 0, "R1 latch", latch, 0);
    chk(data == 0, "R1 data", data, 0);

    // R6 unqualified writes
    wr_fall(1'b0, 1'b1);
    step(40);
    wr_n = 1'b1;
    step(10);
    wr_fall(1'b1, 1'b0);
    step(40);
    chk(rise_cnt == 0 && active == 0, "R6 unqualified write", rise_cnt, 0);
    wr_n = 1'b1;
    step(10);

    // R2 qualified start
    push_result(16'hA5C3);
    wr_fall(1'b1, 1'b1);
    while (rise_cnt < 1) step(1);
    chk(rise_cyc - wr_cyc <= 8, "R2 start latency", rise_cyc - wr_cyc, 8);
    step(20);
    wr_n = 1'b1;

    // R7 early write dropped
    step(1000);
    wr_fall(1'b1, 1'b1);
    step(20);
    wr_n = 1'b1;
    while (fall_cnt < 1) step(1);
    step(REST_CLK - 2);
    chk(active == 1, "R5 active in rest", active, 1);
    step(3);
    chk(active == 0, "R5 active after rest", active, 0);
    step(200);
    chk(rise_cnt == 1, "R7 lockout write", rise_cnt, 1);

    // R8 late write held
    push_result(16'h1234);
    wr_fall(1'b1, 1'b1);
    step(20);
    wr_n = 1'b1;
    while (rise_cnt < 2) step(1);
    step(4500);
    wr_fall(1'b1, 1'b1);   // held low afterwards for R9
    while (fall_cnt < 2) step(1);
    push_result(16'hBEEF);
    while (rise_cnt < 3) step(1);
    chk(rise_cyc - fall_cyc == REST_CLK, "R8 queued restart gap", rise_cyc - fall_cyc, REST_CLK);

    // R9 held-low strobe
    while (fall_cnt < 3) step(1);
    step(1000);
    chk(rise_cnt == 3, "R9 held write", rise_cnt, 3);
    chk(active == 0, "R9 idle", active, 0);
    wr_n = 1'b1;
    step(20);

    // R10 continuous mode
    push_result(16'h0F0F);
    cont_mode = 1'b1;
    while (rise_cnt < 4) step(1);
    wr_fall(1'b1, 1'b1);
    step(20);
    wr_n = 1'b1;
    while (rise_cnt < 5) step(1);
    chk(rise_cyc - fall_cyc == REST_CLK, "R10 back-to-back gap", rise_cyc - fall_cyc, REST_CLK);
    exp_q.push_back(16'h0F0F);
    cont_mode = 1'b0;
    while (fall_cnt < 5) step(1);
    step(REST_CLK + 200);
    chk(rise_cnt == 5, "R10 stop after mode clear", rise_cnt, 5);
    chk(active == 0, "R10 idle", active, 0);
    chk(exp_q.size() == 0, "R4 all results latched", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule